// File: doc/BRIEF.md
# Tap-Select Clock-Enable Prescaler

This block turns a fast system clock into a slower stream of one-cycle enable pulses for a downstream timer. It never produces a derived clock net. A 10-bit synchronous counter runs on every cycle and is never loaded. A 3-bit select code chooses which power-of-two stage of that counter sets the pulse rate. The five available ratios are 1, 8, 64, 256 and 1024. The remaining codes stop the pulses, but the counter keeps running.

The pulse for ratio 2^n is raised on every cycle in which the n lowest counter bits are all ones. The timer that consumes it counts only on cycles where the pulse is high. Changing the select code does not restart the counter. The new ratio therefore lines up with the counter that is already running, so the first pulse after a change may come sooner than a full period. A synchronous reset clears the counter, and this makes the first pulse after reset land exactly one full period after reset is released.

Top module: `tick_prescaler`

## Requirements
- R1: Select codes 3'b000, 3'b110 and 3'b111 produce no pulse on any cycle.
- R2: With code 3'b001 (ratio 1), `tick_o` is high on every cycle while reset is low.
- R3: Codes 3'b010, 3'b011, 3'b100 and 3'b101 give ratios 8, 64, 256 and 1024. With a steady code, a window of W cycles that starts at reset release holds floor(W/R) pulses.
- R4: After reset is released, the first pulse at ratio R comes on cycle R-1, counting the first cycle with reset low as cycle 0. A reset asserted in the middle of a run restarts this timing.
- R5: `tick_o` is low on every cycle while `rst_i` is high, whatever the select code.
- R6: A change of select code does not clear the counter. After a change to ratio 2^n, the first pulse comes on the first cycle whose free-running count, taken modulo 2^n, equals 2^n-1.
- R7: At any ratio above 1 with a steady select code, `tick_o` is never high on two cycles in a row.
- R8: The counter advances by one every cycle that reset is low, and wraps from 1023 to 0. This includes cycles with a stop code, so a ratio chosen later lines up with the time elapsed since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sel_i | input | 3 | Ratio select code |
| tick_o | output | 1 | One-cycle enable pulse at the selected rate |

## Verification
The bench builds the block with its default parameters: a 10-bit chain and taps at stages 0, 3, 6, 8 and 10. With these values the slowest ratio fits in a window of about two thousand cycles, so the 1023-to-0 wrap and a full /1024 period are both reached inside one run. The same values let the bench place code changes at known counter values, such as 100, 1000 and after a stopped stretch. From those points the early first pulse and the uncleared chain can be predicted exactly.

// File: rtl/tick_prescaler_pkg.sv
`timescale 1ns/1ps
package tick_prescaler_pkg;
   localparam int SEL_W    = 3;
   localparam int TAP_FLDW = 6;

   typedef logic [SEL_W-1:0] psel_t;

   // code 0 is always a stop code; codes 1..NUM_TAPS pick a tap in order
   localparam psel_t SEL_HALT = '0;

   function automatic logic sel_is_tap(input psel_t code, input int num_taps);
      return (code != SEL_HALT) && (int'(code) <= num_taps);
   endfunction
endpackage

// File: rtl/prescale_chain.sv
`timescale 1ns/1ps
module prescale_chain #(
   parameter int CHAIN_W = 10
) (
   input  logic               clk_i,
   input  logic               rst_i,
   output logic [CHAIN_W-1:0] count_o
);
   localparam logic [CHAIN_W-1:0] STEP = CHAIN_W'(1);

   generate
      if (CHAIN_W < 1) begin : g_bad_width
         $error("prescale_chain: CHAIN_W must be at least 1");
      end
   endgenerate

   logic [CHAIN_W-1:0] count_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) count_q <= '0;
      else       count_q <= count_q + STEP;
   end

   assign count_o = count_q;

   // R8
   chain_advance_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> (count_q == CHAIN_W'($past(count_q) + STEP)));
endmodule

// File: rtl/prescale_tap_mux.sv
`timescale 1ns/1ps
module prescale_tap_mux
   import tick_prescaler_pkg::*;
#(
   parameter int                           CHAIN_W  = 10,
   parameter int                           NUM_TAPS = 5,
   parameter logic [NUM_TAPS*TAP_FLDW-1:0] TAP_EXPS = '0
) (
   input  logic [CHAIN_W-1:0] count_i,
   input  psel_t              sel_i,
   output logic               hit_o
);
   logic [NUM_TAPS-1:0] stage_hit;

   generate
      if (NUM_TAPS < 1 || NUM_TAPS > (1 << SEL_W) - 1) begin : g_bad_taps
         $error("prescale_tap_mux: NUM_TAPS must fit the select code");
      end
      for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
         localparam int EXP = int'(TAP_EXPS[i*TAP_FLDW +: TAP_FLDW]);
         if (EXP > CHAIN_W) begin : g_too_deep
            $error("prescale_tap_mux: tap deeper than the chain");
         end
         if (i > 0) begin : g_order
            if (EXP <= int'(TAP_EXPS[(i-1)*TAP_FLDW +: TAP_FLDW])) begin : g_not_rising
               $error("prescale_tap_mux: taps must rise strictly");
            end
         end
         if (EXP == 0) begin : g_pass
            assign stage_hit[i] = 1'b1;
         end else begin : g_and
            assign stage_hit[i] = &count_i[EXP-1:0];
         end
      end
   endgenerate

   always_comb begin
      hit_o = 1'b0;
      for (int i = 0; i < NUM_TAPS; i++) begin
         if (sel_i == psel_t'(i + 1)) hit_o = stage_hit[i];
      end
   end
endmodule

// File: rtl/tick_prescaler.sv
`timescale 1ns/1ps
module tick_prescaler
   import tick_prescaler_pkg::*;
#(
   parameter int CHAIN_W  = 10,
   parameter int NUM_TAPS = 5,
   parameter int TAP_A    = 0,
   parameter int TAP_B    = 3,
   parameter int TAP_C    = 6,
   parameter int TAP_D    = 8,
   parameter int TAP_E    = 10
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam logic [NUM_TAPS*TAP_FLDW-1:0] TAP_EXPS = {
      TAP_FLDW'(TAP_E), TAP_FLDW'(TAP_D), TAP_FLDW'(TAP_C),
      TAP_FLDW'(TAP_B), TAP_FLDW'(TAP_A)};

   generate
      if (NUM_TAPS != 5) begin : g_tap_count
         $error("tick_prescaler: the top wires exactly five taps");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain_cnt;
   logic               tap_hit;

   prescale_chain #(.CHAIN_W(CHAIN_W)) u_chain (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .count_o(chain_cnt)
   );

   prescale_tap_mux #(
      .CHAIN_W (CHAIN_W),
      .NUM_TAPS(NUM_TAPS),
      .TAP_EXPS(TAP_EXPS)
   ) u_mux (
      .count_i(chain_cnt),
      .sel_i  (sel_i),
      .hit_o  (tap_hit)
   );

   assign tick_o = ~rst_i & tap_hit;

   // R1
   halt_code_silent_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !sel_is_tap(sel_i, NUM_TAPS) |-> !tick_o);

   // R2
   unit_ratio_steady_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (sel_i == psel_t'(1)) |-> tick_o);

   // R7
   no_double_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick_o && sel_is_tap(sel_i, NUM_TAPS) && sel_i != psel_t'(1))
      |=> (sel_i != $past(sel_i) || !tick_o));

   // R4
   release_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(rst_i) && sel_is_tap(sel_i, NUM_TAPS) && sel_i != psel_t'(1)) |-> !tick_o);
endmodule

// File: tb/sim_tick_prescaler.sv
`timescale 1ns/1ps
module sim_tick_prescaler;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] sel = 3'b000;
   logic       tick;
   int         checks = 0;
   int         errors = 0;

   always #10 clk = ~clk;

   tick_prescaler u0 (
      .clk_i (clk),
      .rst_i (rst),
      .sel_i (sel),
      .tick_o(tick)
   );

   // {sel, window, expected pulses, expected first-pulse cycle (4095 = none)}
   localparam logic [38:0] VEC [8] = '{
      {3'b001, 12'd20,   12'd20, 12'd0},
      {3'b010, 12'd40,   12'd5,  12'd7},
      {3'b011, 12'd200,  12'd3,  12'd63},
      {3'b100, 12'd600,  12'd2,  12'd255},
      {3'b101, 12'd2100, 12'd2,  12'd1023},
      {3'b000, 12'd300,  12'd0,  12'd4095},
      {3'b110, 12'd300,  12'd0,  12'd4095},
      {3'b111, 12'd300,  12'd0,  12'd4095}
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic restart(input logic [2:0] s);
      @(negedge clk);
      rst = 1'b1;
      sel = s;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   // samples W cycles starting at the current low phase
   task automatic observe(input int w, output int n, output int first, output int dbl);
      logic prev = 1'b0;
      n = 0; first = 4095; dbl = 0;
      for (int k = 0; k < w; k++) begin
         #2;
         if (tick) begin
            n++;
            if (first == 4095) first = k;
            if (prev) dbl++;
         end
         prev = tick;
         @(negedge clk);
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n, first, dbl;

      // R5: tick stays low while reset is held, even at ratio 1
      @(negedge clk);
      rst = 1'b1;
      sel = 3'b001;
      repeat (2) @(negedge clk);
      #2 check("R5 tick during reset", int'(tick), 0);

      // Table walk: R1 R2 R3 R4 R7
      for (int v = 0; v < 8; v++) begin
         logic [2:0] s   = VEC[v][38:36];
         int         win = int'(VEC[v][35:24]);
         int         ecnt = int'(VEC[v][23:12]);
         int         efst = int'(VEC[v][11:0]);
         restart(s);
         observe(win, n, first, dbl);
         check($sformatf("R3/R1/R2 pulse count sel=%b", s), n, ecnt);
         check($sformatf("R4 first pulse sel=%b", s), first, efst);
         if (s >= 3'b010 && s <= 3'b101)
            check($sformatf("R7 back-to-back sel=%b", s), dbl, 0);
      end

      // R6: switch /1024 -> /8 at count 100, next pulse at count 103
      restart(3'b101);
      observe(100, n, first, dbl);
      check("R6 no pulse before switch", n, 0);
      sel = 3'b010;
      observe(8, n, first, dbl);
      check("R6 early first pulse after switch", first, 3);

      // R6: switch /1 -> /1024 at count 1000, pulse at count 1023
      restart(3'b001);
      observe(1000, n, first, dbl);
      check("R2 ratio-1 run", n, 1000);
      sel = 3'b101;
      observe(30, n, first, dbl);
      check("R6 pulse at chain 1023", first, 23);

      // R8: chain keeps counting while halted, /64 then lines up with it
      restart(3'b000);
      observe(10, n, first, dbl);
      check("R1 halted window", n, 0);
      sel = 3'b011;
      observe(64, n, first, dbl);
      check("R8 resume aligned to elapsed count", first, 53);

      // R4: reset in mid run restarts the timing
      restart(3'b010);
      observe(5, n, first, dbl);
      restart(3'b010);
      observe(9, n, first, dbl);
      check("R4 first pulse after mid-run reset", first, 7);
      check("R4 pulses after mid-run reset", n, 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule